// File: doc/BRIEF.md
# Dual Wiper Serial Control Port

This block is the digital control port of a two-channel digital potentiometer. A bus master opens a session by raising an enable line. It then clocks a 17-bit frame in on a serial data line, and closes the session by dropping the enable. The frame carries two 8-bit wiper tap settings and one stack-select bit. When the session closes, the block presents them on parallel outputs that drive the resistor network.

Bits pushed past the end of the frame register leave on a cascade output. The next device on a shared bus can take its data from there. A save strobe from power monitoring copies the frame register into a shadow copy. On a warm reset, that copy is loaded back into the frame register and the outputs. A separate cold power-on input clears the shadow copy. The serial lines are asynchronous to the block clock, so they are passed through synchronizer stages and their edges are found in the block clock domain.

Top module: `wiper_port`

## Requirements
- R1: While the enable input is low, serial clock edges and data values change neither the frame register, the wiper outputs, nor the cascade output.
- R2: A session begins only on a low-to-high change of the enable input. If enable is already high when reset is released, no bit is shifted and no output changes until enable has gone low and then high again.
- R3: During a session, the data line is sampled on each rising serial clock edge. Each new bit enters at frame bit 16 and all bits move one place toward bit 0, so the first of 17 bits ends in bit 0. The frame layout is: bit 0 is stack-select; bits 1 to 8 are wiper 1, with bit 1 as its MSB; bits 9 to 16 are wiper 0, with bit 9 as its MSB.
- R4: The wiper and stack-select outputs change only when enable falls at the end of a session (or during reset). They then take the decoded frame register.
- R5: A session with fewer than 17 clocks, including zero, still updates the outputs from the frame register as the partial shift left it.
- R6: The bit pushed out of frame bit 0 by a rising serial clock edge appears on the cascade output after the next falling serial clock edge. Cascade output is 0 after reset.
- R7: A one-cycle save strobe copies the whole frame register into the shadow copy.
- R8: A warm reset loads a valid shadow copy into the frame register and the outputs.
- R9: With no valid shadow copy (after the cold power-on input), reset sets both wipers to 0x80 and stack-select to 0.
- R10: Each wiper covers its full 256-position range, including 0x00 and 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous warm reset, active high; restores from shadow |
| por_i | input | 1 | Synchronous cold power-on, active high; clears the shadow copy |
| pfail_i | input | 1 | One-cycle save strobe: frame register to shadow |
| port_en_i | input | 1 | Session enable, active high, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| wiper0_o | output | 8 | Wiper 0 tap setting |
| wiper1_o | output | 8 | Wiper 1 tap setting |
| stack_o | output | 1 | Stack-select output |
| casc_o | output | 1 | Cascade serial data output |

## Verification
The bench builds the block with its defaults: two synchronizer stages and a mid-scale value of 0x80. With these values the reset default can be checked against a known constant, and serial phases of four block clocks settle well inside one phase. Sessions of 18 to 24 clocks push whole frames out on the cascade output, so its 17-bit delay can be checked bit by bit. Random session lengths from 0 to 24 cover partial frames, exact frames and overflow.

// File: rtl/wp_pkg.sv
package wp_pkg;

    localparam int WIPER_W  = 8;
    localparam int FRAME_W  = 2 * WIPER_W + 1;
    localparam int STACK_IX = 0;
    localparam int W1_BASE  = 1;
    localparam int W0_BASE  = 1 + WIPER_W;
    localparam int LANES    = 3;
    localparam int LANE_EN  = 0;
    localparam int LANE_CLK = 1;
    localparam int LANE_DAT = 2;

    typedef logic [FRAME_W-1:0] frame_t;

    typedef struct packed {
        logic [WIPER_W-1:0] pot0;
        logic [WIPER_W-1:0] pot1;
        logic               stack;
    } setting_t;

    // Field base holds the MSB; higher frame index means lower weight.
    function automatic setting_t frame_to_setting(frame_t f);
        setting_t s;
        s.stack = f[STACK_IX];
        for (int i = 0; i < WIPER_W; i++) begin
            s.pot1[WIPER_W-1-i] = f[W1_BASE+i];
            s.pot0[WIPER_W-1-i] = f[W0_BASE+i];
        end
        return s;
    endfunction

    function automatic frame_t setting_to_frame(setting_t s);
        frame_t f;
        f[STACK_IX] = s.stack;
        for (int i = 0; i < WIPER_W; i++) begin
            f[W1_BASE+i] = s.pot1[WIPER_W-1-i];
            f[W0_BASE+i] = s.pot0[WIPER_W-1-i];
        end
        return f;
    endfunction

endpackage

// File: rtl/wp_sync_chain.sv
module wp_sync_chain #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= RST_VAL;
                else     stage_q[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= RST_VAL;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/wp_session_ctrl.sv
module wp_session_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic en_lvl,
    input  logic sclk_lvl,
    output logic armed,
    output logic shift_stb,
    output logic casc_stb,
    output logic apply_stb
);

    logic en_prev;
    logic sclk_prev;
    logic en_rise;
    logic en_fall;
    logic sclk_rise;
    logic sclk_fall;

    assign en_rise   =  en_lvl   & ~en_prev;
    assign en_fall   = ~en_lvl   &  en_prev;
    assign sclk_rise =  sclk_lvl & ~sclk_prev;
    assign sclk_fall = ~sclk_lvl &  sclk_prev;

    // en_prev resets high so an enable already high at reset never arms.
    always_ff @(posedge clk) begin
        if (rst) begin
            en_prev   <= 1'b1;
            sclk_prev <= 1'b0;
            armed     <= 1'b0;
        end else begin
            en_prev   <= en_lvl;
            sclk_prev <= sclk_lvl;
            if (en_fall)      armed <= 1'b0;
            else if (en_rise) armed <= 1'b1;
        end
    end

    assign shift_stb = armed & sclk_rise;
    assign casc_stb  = armed & sclk_fall;
    assign apply_stb = armed & en_fall;

endmodule

// File: rtl/wp_frame_shifter.sv
module wp_frame_shifter
    import wp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  frame_t restore_frame,
    input  logic   shift_stb,
    input  logic   casc_stb,
    input  logic   sdata,
    output frame_t io_q,
    output logic   casc_o
);

    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            io_q   <= restore_frame;
            pend_q <= 1'b0;
            casc_o <= 1'b0;
        end else begin
            if (shift_stb) begin
                io_q   <= {sdata, io_q[FRAME_W-1:1]};
                pend_q <= io_q[0];
            end
            if (casc_stb) casc_o <= pend_q;
        end
    end

endmodule

// File: rtl/wp_shadow_store.sv
module wp_shadow_store
    import wp_pkg::*;
(
    input  logic   clk,
    input  logic   por,
    input  logic   pfail,
    input  frame_t io_q,
    output frame_t shadow_q,
    output logic   shadow_valid
);

    always_ff @(posedge clk) begin
        if (por) begin
            shadow_q     <= '0;
            shadow_valid <= 1'b0;
        end else if (pfail) begin
            shadow_q     <= io_q;
            shadow_valid <= 1'b1;
        end
    end

endmodule

// File: rtl/wiper_port.sv
module wiper_port
    import wp_pkg::*;
#(
    parameter int                 SYNC_STAGES = 2,
    parameter logic [WIPER_W-1:0] MID_SCALE   = 8'h80
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               por_i,
    input  logic               pfail_i,
    input  logic               port_en_i,
    input  logic               sclk_i,
    input  logic               sdata_i,
    output logic [WIPER_W-1:0] wiper0_o,
    output logic [WIPER_W-1:0] wiper1_o,
    output logic               stack_o,
    output logic               casc_o
);

    localparam logic [LANES-1:0] LANE_RST = LANES'(1) << LANE_EN;
    localparam setting_t         DEF_SET  = '{pot0: MID_SCALE, pot1: MID_SCALE, stack: 1'b0};

    logic [LANES-1:0] lane_raw;
    logic [LANES-1:0] lane_lvl;
    logic             armed;
    logic             shift_stb;
    logic             casc_stb;
    logic             apply_stb;
    frame_t           io_q;
    frame_t           shadow_q;
    logic             shadow_valid;
    frame_t           restore_frame;
    setting_t         out_q;

    assign lane_raw[LANE_EN]  = port_en_i;
    assign lane_raw[LANE_CLK] = sclk_i;
    assign lane_raw[LANE_DAT] = sdata_i;

    wp_sync_chain #(
        .WIDTH  (LANES),
        .STAGES (SYNC_STAGES),
        .RST_VAL(LANE_RST)
    ) u_sync (
        .clk (clk_i),
        .rst (rst_i),
        .din (lane_raw),
        .dout(lane_lvl)
    );

    wp_session_ctrl u_ctrl (
        .clk      (clk_i),
        .rst      (rst_i),
        .en_lvl   (lane_lvl[LANE_EN]),
        .sclk_lvl (lane_lvl[LANE_CLK]),
        .armed    (armed),
        .shift_stb(shift_stb),
        .casc_stb (casc_stb),
        .apply_stb(apply_stb)
    );

    assign restore_frame = shadow_valid ? shadow_q : setting_to_frame(DEF_SET);

    wp_frame_shifter u_shift (
        .clk          (clk_i),
        .rst          (rst_i),
        .restore_frame(restore_frame),
        .shift_stb    (shift_stb),
        .casc_stb     (casc_stb),
        .sdata        (lane_lvl[LANE_DAT]),
        .io_q         (io_q),
        .casc_o       (casc_o)
    );

    wp_shadow_store u_shadow (
        .clk         (clk_i),
        .por         (por_i),
        .pfail       (pfail_i),
        .io_q        (io_q),
        .shadow_q    (shadow_q),
        .shadow_valid(shadow_valid)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i)          out_q <= frame_to_setting(restore_frame);
        else if (apply_stb) out_q <= frame_to_setting(io_q);
    end

    assign wiper0_o = out_q.pot0;
    assign wiper1_o = out_q.pot1;
    assign stack_o  = out_q.stack;

endmodule

// File: rtl/wp_checker.sv
module wp_checker
    import wp_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               por,
    input logic               pfail,
    input logic               en_lvl,
    input logic               sdata_lvl,
    input logic               armed,
    input logic               shift_stb,
    input logic               casc_stb,
    input logic               apply_stb,
    input frame_t             io_q,
    input frame_t             shadow_q,
    input logic [WIPER_W-1:0] wiper0,
    input logic [WIPER_W-1:0] wiper1,
    input logic               stack,
    input logic               casc
);

    a_r1_idle_frame: assert property (@(posedge clk) disable iff (rst)
        !en_lvl |=> $stable(io_q));

    a_r2_arm_on_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> ($past(en_lvl) && !$past(en_lvl, 2)));

    a_r3_bit_enters_top: assert property (@(posedge clk) disable iff (rst)
        shift_stb |=> io_q[FRAME_W-1] == $past(sdata_lvl));

    a_r4_outputs_hold: assert property (@(posedge clk) disable iff (rst)
        !apply_stb |=> ($stable(wiper0) && $stable(wiper1) && $stable(stack)));

    a_r4_stack_applied: assert property (@(posedge clk) disable iff (rst)
        apply_stb |=> stack == $past(io_q[STACK_IX]));

    a_r6_casc_on_fall: assert property (@(posedge clk) disable iff (rst)
        !casc_stb |=> $stable(casc));

    a_r7_shadow_copy: assert property (@(posedge clk) disable iff (por)
        pfail |=> shadow_q == $past(io_q));

endmodule

bind wiper_port wp_checker u_chk (
    .clk      (clk_i),
    .rst      (rst_i),
    .por      (por_i),
    .pfail    (pfail_i),
    .en_lvl   (lane_lvl[wp_pkg::LANE_EN]),
    .sdata_lvl(lane_lvl[wp_pkg::LANE_DAT]),
    .armed    (armed),
    .shift_stb(shift_stb),
    .casc_stb (casc_stb),
    .apply_stb(apply_stb),
    .io_q     (io_q),
    .shadow_q (shadow_q),
    .wiper0   (wiper0_o),
    .wiper1   (wiper1_o),
    .stack    (stack_o),
    .casc     (casc_o)
);

// File: tb/sim_wiper_port.sv
module sim_wiper_port;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst, por, pfail, en, sclk, sdata;
    logic [7:0] w0, w1;
    logic       stk, casc;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    logic [16:0] io_m;
    logic [16:0] shadow_m;
    bit          shadow_ok;
    logic        casc_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    wiper_port u0 (
        .clk_i(clk), .rst_i(rst), .por_i(por), .pfail_i(pfail),
        .port_en_i(en), .sclk_i(sclk), .sdata_i(sdata),
        .wiper0_o(w0), .wiper1_o(w1), .stack_o(stk), .casc_o(casc)
    );

    function automatic logic [16:0] pack_f(logic [7:0] a0, logic [7:0] a1, logic s);
        logic [16:0] f;
        f[0] = s;
        for (int i = 0; i < 8; i++) begin
            f[1+i] = a1[7-i];
            f[9+i] = a0[7-i];
        end
        return f;
    endfunction

    function automatic logic [7:0] w0_of(logic [16:0] f);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[7-i] = f[9+i];
        return v;
    endfunction

    function automatic logic [7:0] w1_of(logic [16:0] f);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[7-i] = f[1+i];
        return v;
    endfunction

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_outs(string req);
        check({req, " wiper0"}, {24'd0, w0}, {24'd0, w0_of(io_m)});
        check({req, " wiper1"}, {24'd0, w1}, {24'd0, w1_of(io_m)});
        check({req, " stack"},  {31'd0, stk}, {31'd0, io_m[0]});
    endtask

    // bits[k] is the k-th bit sent; every cascade change is checked (R6).
    task automatic session(logic [31:0] bits, int n);
        logic pend;
        en = 1'b1;
        wait_n(6);
        for (int k = 0; k < n; k++) begin
            sdata = bits[k];
            wait_n(4);
            sclk = 1'b1;
            pend = io_m[0];
            io_m = {bits[k], io_m[16:1]};
            wait_n(4);
            sclk = 1'b0;
            wait_n(6);
            casc_m = pend;
            check("R6 cascade", {31'd0, casc}, {31'd0, casc_m});
        end
        en = 1'b0;
        wait_n(8);
    endtask

    task automatic do_reset(bit cold, bit en_high);
        en  = en_high;
        rst = 1'b1;
        por = cold;
        wait_n(6);
        rst = 1'b0;
        por = 1'b0;
        if (cold) shadow_ok = 0;
        io_m   = shadow_ok ? shadow_m : pack_f(8'h80, 8'h80, 1'b0);
        casc_m = 1'b0;
        wait_n(4);
    endtask

    initial begin
        logic [16:0] fa;
        logic [31:0] rb;
        int          rn;
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; por = 1'b1; pfail = 1'b0; en = 1'b0; sclk = 1'b0; sdata = 1'b0;
        shadow_ok = 0;
        do_reset(1'b1, 1'b0);

        // R9: empty shadow gives mid-scale and stack 0
        check("R9 wiper0 default", {24'd0, w0}, 32'h80);
        check("R9 wiper1 default", {24'd0, w1}, 32'h80);
        check("R9 stack default",  {31'd0, stk}, 32'd0);
        check("R6 cascade reset",  {31'd0, casc}, 32'd0);

        // R3 / R10: full frames at range ends and MSB placement
        session({15'd0, pack_f(8'hFF, 8'h00, 1'b1)}, 17);
        check_outs("R10 ends");
        check("R10 wiper0 FF", {24'd0, w0}, 32'hFF);
        session({15'd0, pack_f(8'h00, 8'hFF, 1'b0)}, 17);
        check_outs("R10 ends swap");
        session({15'd0, pack_f(8'h01, 8'h80, 1'b1)}, 17);
        check("R3 wiper0 lsb", {24'd0, w0}, 32'h01);
        check("R3 wiper1 msb", {24'd0, w1}, 32'h80);
        check("R3 stack",      {31'd0, stk}, 32'd1);

        // R1: clock and data with enable low are ignored
        for (int k = 0; k < 6; k++) begin
            sdata = k[0];
            wait_n(4); sclk = 1'b1; wait_n(4); sclk = 1'b0; wait_n(4);
        end
        check_outs("R1 idle outputs");
        check("R1 idle cascade", {31'd0, casc}, {31'd0, casc_m});
        session(32'd0, 0);
        check_outs("R1 idle frame readback");

        // R5: partial frames
        session(32'h0000_0015, 5);
        check_outs("R5 partial 5");
        session(32'h0000_0000, 0);
        check_outs("R5 zero clocks");

        // R6: overflow pushes the previous frame out
        session(32'h00A5_5A3C, 24);
        check_outs("R6 long frame");

        // R4 / R5 / R6: random sessions
        for (int t = 0; t < 20; t++) begin
            rb = $urandom;
            rn = int'($urandom_range(0, 24));
            session(rb, rn);
            check_outs("R4 random");
        end

        // R7 / R8: save, overwrite, warm reset restores
        fa = pack_f(8'h3C, 8'hC3, 1'b1);
        session({15'd0, fa}, 17);
        pfail = 1'b1; wait_n(1); pfail = 1'b0;
        shadow_m = io_m; shadow_ok = 1;
        session({15'd0, pack_f(8'h11, 8'h22, 1'b0)}, 17);
        check_outs("R4 overwrite");
        do_reset(1'b0, 1'b0);
        check("R8 wiper0 restored", {24'd0, w0}, 32'h3C);
        check("R8 wiper1 restored", {24'd0, w1}, 32'hC3);
        check("R7 stack restored",  {31'd0, stk}, 32'd1);

        // R2: enable already high at reset does not open a session
        do_reset(1'b0, 1'b1);
        for (int k = 0; k < 3; k++) begin
            sdata = 1'b1;
            wait_n(4); sclk = 1'b1; wait_n(4); sclk = 1'b0; wait_n(4);
        end
        en = 1'b0;
        wait_n(8);
        check_outs("R2 no session");
        session(32'd0, 0);
        check_outs("R2 frame untouched");

        // R9: cold reset clears shadow
        do_reset(1'b1, 1'b0);
        check("R9 wiper0 cold", {24'd0, w0}, 32'h80);
        check("R9 wiper1 cold", {24'd0, w1}, 32'h80);
        check("R9 stack cold",  {31'd0, stk}, 32'd0);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule